// File: doc/BRIEF.md
# CCD Line Readout Timing Generator

This block produces the digital clocking for one readout line of a full-frame CCD image sensor. It runs from a master clock at six times the pixel rate. An internal sub-phase counter divides each pixel period into six slots. Those slots set the 120-degree register-clock phases and the one-sixth-period reset-gate pulse.

A line request received while the block is idle starts a line of 3487 pixel periods. The first 360 periods form the vertical transfer interval. In it, four overlapping image-clock phases move one row into the output register, and the transport-high flag may raise the image-clock level. The remaining 3127 periods form the horizontal readout. In it, the register-clock start-stop flag is active, three register clocks and the summing and reset gates run, and a region code marks each pixel. The pixels come in a fixed order: 7 dummy, 20 black, 4 timing, 3072 active, 4 timing, 20 black.

The start offsets of the four image-clock phases and the start of a 30-period black-clamp window are held in registers. These registers can be written only between lines.

Top module: `ccd_line_timer`

## Requirements
- R1: When the block is idle, a high `line_req_i` on a clock edge starts a line. From the next edge on, `busy_o` stays high for 3487 pixel periods of 6 master clocks each. Within a period the sub-phase numbers 0 to 5 run in order, and pixel 0 begins with sub-phase 0. `line_done_o` is high for exactly one master clock: sub-phase 5 of pixel 3486. After that, `busy_o` falls.
- R2: A `line_req_i` that arrives while `busy_o` is high is ignored. The line under way keeps its timing, and no extra line follows it.
- R3: Image phase k (bit k of `img_clk_o`) is high while the pixel index p satisfies off_k <= p < off_k+138 and also p < 360. Outside that range it is low. After reset, off_0..off_3 are 0, 20, 112 and 204.
- R4: `ssc_o` is high exactly for pixels 360 to 3486 of a line.
- R5: While `ssc_o` is high, the register clocks follow the sub-phase s. Bit 0 is high for s in {0,1,2}, bit 1 for s in {2,3,4}, and bit 2 for s in {4,5,0}. While `ssc_o` is low, all three are low.
- R6: While `ssc_o` is high, `sum_gate_o` is high for s in {3,4,5} and `reset_gate_o` is high only for s = 0. Both are low otherwise.
- R7: `pix_kind_o` encodes the readout position h = p-360. It is 1 (dummy) for h < 7, 2 (black) for 7..26, 3 (timing) for 27..30, 4 (active) for 31..3102, 3 for 3103..3106, and 2 for 3107..3126. It is 0 outside readout.
- R8: `clamp_o` is high for 30 pixel periods starting at the clamp-start register value, p in [c, c+30). It is high only during a line. After reset, c is 396.
- R9: `ahigh_o` is high throughout pixels 0..359 of a line only if `readout_i` was high on the edge that started the line. Otherwise it stays low.
- R10: A high `cfg_we_i` while idle writes `cfg_data_i` to one register. `cfg_addr_i` 0 to 3 select off_0..off_3, 4 selects the clamp start, and other addresses write nothing. A write while `busy_o` is high is ignored.
- R11: While `rst_ni` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, six times pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_req_i | input | 1 | Line start request |
| readout_i | input | 1 | Enables transport-high flag for the line being started |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register select |
| cfg_data_i | input | 12 | Configuration write value (pixel periods) |
| img_clk_o | output | 4 | Vertical image-clock phases |
| reg_clk_o | output | 3 | Horizontal register-clock phases |
| sum_gate_o | output | 1 | Summing gate |
| reset_gate_o | output | 1 | Reset gate pulse |
| ssc_o | output | 1 | Register-clock start-stop flag |
| clamp_o | output | 1 | Black-level-clamp window |
| ahigh_o | output | 1 | Transport-high flag |
| pix_kind_o | output | 3 | Readout region code |
| busy_o | output | 1 | Line in progress |
| line_done_o | output | 1 | Final master clock of the line |

## Verification
The hardest situations to reach from the ports are a request or a configuration write that lands in the middle of a line, and an image phase whose window runs past the end of the vertical interval. The stimulus programs off_3 to 300, so its 138-period window would reach pixel 437 and has to be cut off at 359. In a later line, a request and a write to off_0 arrive about 800 pixel periods into the line. The line after that is then predicted with the old offset. Any restart, shortened line or accepted write therefore shows up as a mismatch against the predicted pattern.

// File: rtl/ccd_tim_pkg.sv
package ccd_tim_pkg;
  localparam int unsigned SUB_DIV = 6;
  localparam int unsigned SUB_W   = 3;
  localparam int unsigned NUM_IMG = 4;
  localparam int unsigned NUM_REG = 3;

  typedef enum logic [2:0] {
    KIND_NONE   = 3'd0,
    KIND_DUMMY  = 3'd1,
    KIND_BLACK  = 3'd2,
    KIND_TIMING = 3'd3,
    KIND_ACTIVE = 3'd4
  } pix_kind_e;
endpackage

// File: rtl/ccd_line_counter.sv
module ccd_line_counter
  import ccd_tim_pkg::*;
#(
  parameter int unsigned LINE_LEN = 3487,
  parameter int unsigned PIX_W    = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [SUB_W-1:0] sub_o,
  output logic [PIX_W-1:0] pix_o,
  output logic             last_o
);
  localparam logic [PIX_W-1:0] LAST_PIX = PIX_W'(LINE_LEN - 1);
  localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(SUB_DIV - 1);

  logic             busy_q;
  logic [SUB_W-1:0] sub_q;
  logic [PIX_W-1:0] pix_q;

  assign last_o = busy_q && (pix_q == LAST_PIX) && (sub_q == LAST_SUB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sub_q  <= '0;
      pix_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        sub_q  <= '0;
        pix_q  <= '0;
      end
    end else if (sub_q == LAST_SUB) begin
      sub_q <= '0;
      if (pix_q == LAST_PIX) busy_q <= 1'b0;
      else                   pix_q  <= pix_q + 1'b1;
    end else begin
      sub_q <= sub_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign sub_o  = sub_q;
  assign pix_o  = pix_q;
endmodule

// File: rtl/ccd_vert_phases.sv
module ccd_vert_phases
  import ccd_tim_pkg::*;
#(
  parameter int unsigned PIX_W      = 12,
  parameter int unsigned PHASE_HIGH = 138
) (
  input  logic                           vert_win_i,
  input  logic [PIX_W-1:0]               pix_i,
  input  logic [NUM_IMG-1:0][PIX_W-1:0]  off_i,
  output logic [NUM_IMG-1:0]             img_o
);
  localparam int unsigned EXT_W = PIX_W + 1;

  for (genvar k = 0; k < NUM_IMG; k++) begin : g_phase
    logic [EXT_W-1:0] end_pix;
    assign end_pix  = {1'b0, off_i[k]} + EXT_W'(PHASE_HIGH);
    // window is clipped by the vertical interval
    assign img_o[k] = vert_win_i && (pix_i >= off_i[k]) && ({1'b0, pix_i} < end_pix);
  end
endmodule

// File: rtl/ccd_horiz_phases.sv
module ccd_horiz_phases
  import ccd_tim_pkg::*;
#(
  parameter int unsigned PIX_W      = 12,
  parameter int unsigned DUMMY_LEN  = 7,
  parameter int unsigned BLACK_LEN  = 20,
  parameter int unsigned TIMING_LEN = 4,
  parameter int unsigned ACTIVE_LEN = 3072
) (
  input  logic               run_i,
  input  logic [SUB_W-1:0]   sub_i,
  input  logic [PIX_W-1:0]   hpos_i,
  output logic [NUM_REG-1:0] reg_clk_o,
  output logic               sum_gate_o,
  output logic               reset_gate_o,
  output pix_kind_e          kind_o
);
  localparam int unsigned SHIFT  = SUB_DIV / NUM_REG;
  localparam int unsigned HALF   = SUB_DIV / 2;
  localparam int unsigned B0_END = DUMMY_LEN;
  localparam int unsigned T0_END = B0_END + BLACK_LEN;
  localparam int unsigned A_BEG  = T0_END + TIMING_LEN;
  localparam int unsigned A_END  = A_BEG + ACTIVE_LEN;
  localparam int unsigned T1_END = A_END + TIMING_LEN;

  for (genvar k = 0; k < NUM_REG; k++) begin : g_reg
    logic [SUB_W:0] rel;
    always_comb begin
      rel = {1'b0, sub_i} + (SUB_W+1)'(SUB_DIV - k * SHIFT);
      if (rel >= (SUB_W+1)'(SUB_DIV)) rel = rel - (SUB_W+1)'(SUB_DIV);
    end
    assign reg_clk_o[k] = run_i && (rel < (SUB_W+1)'(HALF));
  end

  assign sum_gate_o   = run_i && (sub_i >= SUB_W'(HALF));
  assign reset_gate_o = run_i && (sub_i == '0);

  always_comb begin
    if (!run_i)                         kind_o = KIND_NONE;
    else if (hpos_i < PIX_W'(B0_END))   kind_o = KIND_DUMMY;
    else if (hpos_i < PIX_W'(T0_END))   kind_o = KIND_BLACK;
    else if (hpos_i < PIX_W'(A_BEG))    kind_o = KIND_TIMING;
    else if (hpos_i < PIX_W'(A_END))    kind_o = KIND_ACTIVE;
    else if (hpos_i < PIX_W'(T1_END))   kind_o = KIND_TIMING;
    else                                kind_o = KIND_BLACK;
  end
endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_tim_pkg::*;
#(
  parameter int unsigned VERT_LEN   = 360,
  parameter int unsigned DUMMY_LEN  = 7,
  parameter int unsigned BLACK_LEN  = 20,
  parameter int unsigned TIMING_LEN = 4,
  parameter int unsigned ACTIVE_LEN = 3072,
  parameter int unsigned PHASE_HIGH = 138,
  parameter int unsigned CLAMP_LEN  = 30,
  parameter int unsigned OFF0_RST   = 0,
  parameter int unsigned OFF1_RST   = 20,
  parameter int unsigned OFF2_RST   = 112,
  parameter int unsigned OFF3_RST   = 204,
  parameter int unsigned CLAMP_RST  = 396,
  parameter int unsigned CFG_AW     = 3,
  parameter int unsigned PIX_W      = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_req_i,
  input  logic              readout_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [PIX_W-1:0]  cfg_data_i,
  output logic [3:0]        img_clk_o,
  output logic [2:0]        reg_clk_o,
  output logic              sum_gate_o,
  output logic              reset_gate_o,
  output logic              ssc_o,
  output logic              clamp_o,
  output logic              ahigh_o,
  output logic [2:0]        pix_kind_o,
  output logic              busy_o,
  output logic              line_done_o
);
  localparam int unsigned HORIZ_LEN = DUMMY_LEN + 2 * (BLACK_LEN + TIMING_LEN) + ACTIVE_LEN;
  localparam int unsigned LINE_LEN  = VERT_LEN + HORIZ_LEN;
  localparam int unsigned EXT_W     = PIX_W + 1;
  localparam logic [CFG_AW-1:0] ADDR_CLAMP = CFG_AW'(NUM_IMG);

  logic             busy;
  logic [SUB_W-1:0] sub;
  logic [PIX_W-1:0] pix;
  logic             last;
  logic             vert_win;
  logic             horiz_win;
  logic             readout_q;
  logic [NUM_IMG-1:0][PIX_W-1:0] off_q;
  logic [PIX_W-1:0] clamp_q;
  logic [EXT_W-1:0] clamp_end;
  logic [PIX_W-1:0] hpos;
  pix_kind_e        kind;

  ccd_line_counter #(.LINE_LEN(LINE_LEN), .PIX_W(PIX_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (line_req_i),
    .busy_o  (busy),
    .sub_o   (sub),
    .pix_o   (pix),
    .last_o  (last)
  );

  assign vert_win  = busy && (pix < PIX_W'(VERT_LEN));
  assign horiz_win = busy && !vert_win;
  assign hpos      = pix - PIX_W'(VERT_LEN);

  // configuration only changes between lines
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q[0]  <= PIX_W'(OFF0_RST);
      off_q[1]  <= PIX_W'(OFF1_RST);
      off_q[2]  <= PIX_W'(OFF2_RST);
      off_q[3]  <= PIX_W'(OFF3_RST);
      clamp_q   <= PIX_W'(CLAMP_RST);
      readout_q <= 1'b0;
    end else if (!busy) begin
      if (line_req_i) readout_q <= readout_i;
      if (cfg_we_i) begin
        if (cfg_addr_i < CFG_AW'(NUM_IMG)) off_q[cfg_addr_i[1:0]] <= cfg_data_i;
        else if (cfg_addr_i == ADDR_CLAMP) clamp_q <= cfg_data_i;
      end
    end
  end

  ccd_vert_phases #(.PIX_W(PIX_W), .PHASE_HIGH(PHASE_HIGH)) u_vert (
    .vert_win_i (vert_win),
    .pix_i      (pix),
    .off_i      (off_q),
    .img_o      (img_clk_o)
  );

  ccd_horiz_phases #(
    .PIX_W(PIX_W), .DUMMY_LEN(DUMMY_LEN), .BLACK_LEN(BLACK_LEN),
    .TIMING_LEN(TIMING_LEN), .ACTIVE_LEN(ACTIVE_LEN)
  ) u_horiz (
    .run_i        (horiz_win),
    .sub_i        (sub),
    .hpos_i       (hpos),
    .reg_clk_o    (reg_clk_o),
    .sum_gate_o   (sum_gate_o),
    .reset_gate_o (reset_gate_o),
    .kind_o       (kind)
  );

  assign clamp_end   = {1'b0, clamp_q} + EXT_W'(CLAMP_LEN);
  assign clamp_o     = busy && (pix >= clamp_q) && ({1'b0, pix} < clamp_end);
  assign ahigh_o     = vert_win && readout_q;
  assign ssc_o       = horiz_win;
  assign pix_kind_o  = kind;
  assign busy_o      = busy;
  assign line_done_o = last;
endmodule

// File: rtl/ccd_line_timer_chk.sv
module ccd_line_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       line_done_o,
  input logic       ssc_o,
  input logic       ahigh_o,
  input logic       clamp_o,
  input logic       sum_gate_o,
  input logic       reset_gate_o,
  input logic [3:0] img_clk_o,
  input logic [2:0] reg_clk_o
);
  // R1
  done_ends_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |=> !busy_o);

  // R2
  line_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !line_done_o) |=> busy_o);

  // R3
  img_in_vert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (img_clk_o != 4'd0) |-> (busy_o && !ssc_o));

  // R4
  ssc_one_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ssc_o) |-> $past(line_done_o));

  // R5
  reg_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ssc_o |-> ($countones(reg_clk_o) == 1 || $countones(reg_clk_o) == 2));

  // R6
  rg_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_gate_o |-> (ssc_o && reg_clk_o[0] && reg_clk_o[2] && !sum_gate_o));

  // R8
  clamp_in_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_o |-> busy_o);

  // R9
  ahigh_vert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ahigh_o |-> (busy_o && !ssc_o));
endmodule

bind ccd_line_timer ccd_line_timer_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .line_done_o  (line_done_o),
  .ssc_o        (ssc_o),
  .ahigh_o      (ahigh_o),
  .clamp_o      (clamp_o),
  .sum_gate_o   (sum_gate_o),
  .reset_gate_o (reset_gate_o),
  .img_clk_o    (img_clk_o),
  .reg_clk_o    (reg_clk_o)
);

// File: tb/ccd_line_timer_test.sv
module ccd_line_timer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        line_req_i = 1'b0;
  logic        readout_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_addr_i = '0;
  logic [11:0] cfg_data_i = '0;
  logic [3:0]  img_clk_o;
  logic [2:0]  reg_clk_o;
  logic        sum_gate_o, reset_gate_o, ssc_o, clamp_o, ahigh_o, busy_o, line_done_o;
  logic [2:0]  pix_kind_o;

  int checks = 0;
  int errors = 0;
  string extra_tag = "";
  logic [16:0] exp_q[$];

  always #10 clk_i = ~clk_i;

  ccd_line_timer uut (.*);

  // {busy,done,img[3:0],reg[2:0],sg,rg,ssc,clamp,ahigh,kind[2:0]}
  function automatic logic [16:0] expect_at(int p, int s, int o0, int o1, int o2, int o3,
                                            int c, bit ro);
    int offs[4];
    logic [3:0] img;
    logic [2:0] rc, kd;
    bit v, h;
    int hp;
    offs[0] = o0; offs[1] = o1; offs[2] = o2; offs[3] = o3;
    v = (p < 360);
    h = !v;
    for (int k = 0; k < 4; k++) img[k] = v && (p >= offs[k]) && (p < offs[k] + 138);
    rc[0] = h && (s == 0 || s == 1 || s == 2);
    rc[1] = h && (s == 2 || s == 3 || s == 4);
    rc[2] = h && (s == 4 || s == 5 || s == 0);
    hp = p - 360;
    if (!h)             kd = 3'd0;
    else if (hp < 7)    kd = 3'd1;
    else if (hp < 27)   kd = 3'd2;
    else if (hp < 31)   kd = 3'd3;
    else if (hp < 3103) kd = 3'd4;
    else if (hp < 3107) kd = 3'd3;
    else                kd = 3'd2;
    return {1'b1, (p == 3486 && s == 5), img, rc, h && s >= 3, h && s == 0, h,
            (p >= c && p < c + 30), ro && v, kd};
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, extra_tag, act, exp, $time);
    end
  endtask

  // monitor: pops one expected item per master clock
  initial begin
    forever begin
      @(negedge clk_i);
      if (exp_q.size() > 0) begin
        logic [16:0] e;
        e = exp_q.pop_front();
        check("R1 busy", busy_o, e[16]);
        check("R1 done", line_done_o, e[15]);
        check("R3 img", img_clk_o, e[14:11]);
        check("R5 reg", reg_clk_o, e[10:8]);
        check("R6 sg", sum_gate_o, e[7]);
        check("R6 rg", reset_gate_o, e[6]);
        check("R4 ssc", ssc_o, e[5]);
        check("R8 clamp", clamp_o, e[4]);
        check("R9 ahigh", ahigh_o, e[3]);
        check("R7 kind", pix_kind_o, e[2:0]);
      end
    end
  end

  task automatic cfg_write(int addr, int data);
    @(posedge clk_i); #2;
    cfg_we_i = 1'b1; cfg_addr_i = 3'(addr); cfg_data_i = 12'(data);
    @(posedge clk_i); #2;
    cfg_we_i = 1'b0;
  endtask

  // driver: queue the whole line, then issue the request
  task automatic run_line(bit ro, int o0, int o1, int o2, int o3, int c, bit inject);
    @(posedge clk_i); #2;
    exp_q.push_back(17'd0);
    for (int p = 0; p < 3487; p++)
      for (int s = 0; s < 6; s++)
        exp_q.push_back(expect_at(p, s, o0, o1, o2, o3, c, ro));
    for (int i = 0; i < 3; i++) exp_q.push_back(17'd0);
    line_req_i = 1'b1; readout_i = ro;
    @(posedge clk_i); #2;
    line_req_i = 1'b0; readout_i = 1'b0;
    if (inject) begin
      repeat (4800) @(posedge clk_i);
      #2;
      // R2: request mid-line is ignored; R10: write mid-line is ignored
      line_req_i = 1'b1; readout_i = 1'b1;
      cfg_we_i = 1'b1; cfg_addr_i = 3'd0; cfg_data_i = 12'd200;
      @(posedge clk_i); #2;
      line_req_i = 1'b0; readout_i = 1'b0; cfg_we_i = 1'b0;
    end
    wait (exp_q.size() == 0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL R1 watchdog: actual %0d cycles expected below 150000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R11: outputs low in reset
    check("R11 img", img_clk_o, 0);
    check("R11 reg", reg_clk_o, 0);
    check("R11 gates", {sum_gate_o, reset_gate_o, ssc_o, clamp_o, ahigh_o}, 0);
    check("R11 kind", pix_kind_o, 0);
    check("R11 busy", {busy_o, line_done_o}, 0);
    @(posedge clk_i); #2;
    rst_ni = 1'b1;

    extra_tag = "R3 reset offsets";
    run_line(1'b1, 0, 20, 112, 204, 396, 1'b0);

    extra_tag = "R10 idle writes";
    cfg_write(0, 5);
    cfg_write(1, 40);
    cfg_write(2, 150);
    cfg_write(3, 300);
    cfg_write(4, 370);
    cfg_write(6, 9);
    extra_tag = "R2 R10 mid-line";
    run_line(1'b0, 5, 40, 150, 300, 370, 1'b1);

    extra_tag = "R10 ignored write";
    run_line(1'b1, 5, 40, 150, 300, 370, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule